// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Queue

This block recovers asynchronous serial characters from a single input line. It uses a sub-bit strobe supplied by an external rate generator and takes `OVS` strobes per bit. The character length, the parity rule and the number of stop bits are set by static configuration inputs. Each received character goes into a first-in first-out queue together with its own set of error flags. The consumer therefore learns which character was corrupted and how, not only that some error happened.

The head of the queue is presented all the time. The consumer reads the error flags of the head first, then the data, and then pulses `rdPop` to discard that entry. Three interrupt lines are provided. One reports that the fill level has reached a chosen threshold. One reports that the head entry carries an error. One reports that the line has stayed idle for a while after the last character. The idle interrupt is raised even when the queue has already been drained.

Top module: `uart_rxe_top`

## Requirements
- R1: `dataBitsSel` selects a character length of `dataBitsSel + 5` bits (5 to 8). Bits arrive least significant first after the start bit and appear right-justified on `rdData`, with the unused upper bits at zero.
- R2: `stopSel` = 0 expects one stop bit and `stopSel` = 1 expects two. If any expected stop bit samples low, `errStatus[2]` (framing) is set for that character.
- R3: The `parityMode` codes are: 0 no parity bit; 1 even; 2 odd; 3 parity bit always 1; 4 parity bit always 0; 5 to 7 behave as 0. When a parity bit is expected and does not match the rule, `errStatus[1]` is set.
- R4: If every sampled bit of a frame is low (start, data, parity and all stop bits), `errStatus[3]` (break) is set, together with framing, and the stored data is zero.
- R5: Characters leave in arrival order. `rdData` and `errStatus` show the head entry, a one-cycle `rdPop` removes it, and both read as zero while the queue is empty.
- R6: A character that completes while the queue holds `DEPTH` entries, and no pop happens in that cycle, is discarded. `errStatus[0]` (overrun) then reads 1 on the head entry until the next pop.
- R7: `fifoCount` gives the entry count modulo `DEPTH` and `fifoFull` is 1 at `DEPTH` entries, so full = 1 with count = 0 means 16 entries by default.
- R8: `irqLevel` is 1 while the entry count is at least the threshold chosen by `trigSel`: code 0 = 1 entry, 1 = DEPTH/4, 2 = DEPTH/2, 3 = 3·DEPTH/4 (1, 4, 8, 12 by default).
- R9: `irqError` is 1 exactly when the queue is non-empty and the head `errStatus` is non-zero.
- R10: After a character completes, `TO_BITS` bit times of high idle line set `irqTimeout`, whatever the queue holds. `toAck` clears it, and a new start bit clears it too.
- R11: Holding `rxEnable` low empties the queue, drops any pending overrun and returns the receiver to idle. A one-cycle `fifoClear` empties the queue and drops the pending overrun.
- R12: Each bit is sampled on sub-strobe index `OVS/2-1` counted from the start-bit detection. A start bit that reads high there is treated as a glitch and yields no character.
- R13: After reset the queue is empty and all three interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable; low holds everything cleared |
| fifoClear | input | 1 | One-cycle queue clear |
| subTick | input | 1 | Sub-bit strobe, OVS per bit |
| rxIn | input | 1 | Serial line, idle high |
| dataBitsSel | input | 2 | Character length minus 5 |
| parityMode | input | 3 | Parity rule code |
| stopSel | input | 1 | Stop bits minus 1 |
| trigSel | input | 2 | Fill-level threshold code |
| rdPop | input | 1 | Remove head entry |
| toAck | input | 1 | Clear idle interrupt |
| rdData | output | 8 | Head character |
| errStatus | output | 4 | Head flags: [3] break, [2] framing, [1] parity, [0] overrun |
| fifoCount | output | 4 | Entry count modulo DEPTH |
| fifoFull | output | 1 | Queue holds DEPTH entries |
| irqLevel | output | 1 | Fill threshold reached |
| irqError | output | 1 | Head entry has an error |
| irqTimeout | output | 1 | Idle line after a character |

## Verification
The receive path is exercised with random characters under random length, parity and stop settings. Within each batch some frames are clean, some carry a flipped parity bit, some have a chosen stop bit pulled low, and some are held low end to end. These frame kinds separate the parity, framing and break flags, and show that each flag stays with its own entry. Directed cases cover the following: a 5-bit character with the upper bits sent high, which shows the right-justification; a short low pulse, which must be rejected as a glitch; seventeen back-to-back characters, which show the full encoding, the overrun tag on the head and the loss of the last character; and an idle wait after the queue has been emptied, which shows that the timeout does not depend on the queue contents.

// File: rtl/uart_rxe_pkg.sv
package uart_rxe_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rxErr_t;

  typedef struct packed {
    logic       startFrame;
    logic       takeData;
    logic [2:0] bitIdx;
    logic       takeParity;
    logic       takeStop;
    logic       pushChar;
    logic       flush;
  } rxStrobe_t;
endpackage

// File: rtl/uart_rxe_ctrl.sv
module uart_rxe_ctrl
  import uart_rxe_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int TO_BITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       fifoClear,
  input  logic       subTick,
  input  logic       rxIn,
  input  logic [1:0] dataBitsSel,
  input  logic       parityOn,
  input  logic       stopSel,
  input  logic       toAck,
  output rxStrobe_t  strb,
  output logic       irqTimeout
);
  localparam int SW = $clog2(OVS);
  localparam int TW = $clog2(TO_BITS * OVS);
  localparam logic [SW-1:0] MID  = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);
  localparam logic [TW-1:0] TO_LIMIT = TW'(TO_BITS * OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PARITY, S_STOP, S_WAITHI} rxState_e;

  rxState_e      state;
  logic [SW-1:0] tickCnt;
  logic [2:0]    bitCnt;
  logic          stopCnt;
  logic          pushNext;
  logic          toArmed;
  logic          toFlag;
  logic [TW-1:0] toCnt;
  logic [2:0]    lastData;
  logic          sampleNow;

  assign lastData  = 3'(dataBitsSel) + 3'd4;
  assign sampleNow = rxEnable && subTick && (tickCnt == MID);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; tickCnt <= '0; bitCnt <= '0; stopCnt <= 1'b0;
      pushNext <= 1'b0; toArmed <= 1'b0; toCnt <= '0; toFlag <= 1'b0;
    end else if (!rxEnable) begin
      state <= S_IDLE; tickCnt <= '0; bitCnt <= '0; stopCnt <= 1'b0;
      pushNext <= 1'b0; toArmed <= 1'b0; toCnt <= '0; toFlag <= 1'b0;
    end else begin
      pushNext <= 1'b0;
      if (toAck) toFlag <= 1'b0;
      if (subTick) begin
        unique case (state)
          S_IDLE: begin
            if (!rxIn) begin
              state   <= S_START;
              tickCnt <= SW'(1);
              toFlag  <= 1'b0;
              toArmed <= 1'b0;
              toCnt   <= '0;
            end else if (toArmed) begin
              if (toCnt == TO_LIMIT) begin
                toFlag  <= 1'b1;
                toArmed <= 1'b0;
              end else begin
                toCnt <= toCnt + TW'(1);
              end
            end
          end
          S_START: begin
            tickCnt <= tickCnt + SW'(1);
            if (tickCnt == MID && rxIn) begin
              state <= S_IDLE;
            end else if (tickCnt == LAST) begin
              state  <= S_DATA;
              bitCnt <= '0;
            end
          end
          S_DATA: begin
            tickCnt <= tickCnt + SW'(1);
            if (tickCnt == LAST) begin
              if (bitCnt == lastData) begin
                state   <= parityOn ? S_PARITY : S_STOP;
                stopCnt <= 1'b0;
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
          S_PARITY: begin
            tickCnt <= tickCnt + SW'(1);
            if (tickCnt == LAST) begin
              state   <= S_STOP;
              stopCnt <= 1'b0;
            end
          end
          S_STOP: begin
            tickCnt <= tickCnt + SW'(1);
            if (tickCnt == MID && stopCnt == stopSel) begin
              pushNext <= 1'b1;
              toArmed  <= 1'b1;
              toCnt    <= '0;
              state    <= rxIn ? S_IDLE : S_WAITHI;
            end else if (tickCnt == LAST) begin
              stopCnt <= 1'b1;
            end
          end
          S_WAITHI: if (rxIn) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.startFrame = rxEnable && subTick && (state == S_IDLE) && !rxIn;
    strb.takeData   = sampleNow && (state == S_DATA);
    strb.bitIdx     = bitCnt;
    strb.takeParity = sampleNow && (state == S_PARITY);
    strb.takeStop   = sampleNow && (state == S_STOP);
    strb.pushChar   = pushNext;
    strb.flush      = !rxEnable || fifoClear;
  end

  assign irqTimeout = toFlag;

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_START && subTick && tickCnt == MID && rxIn) |=> state == S_IDLE); // R12
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeData, strb.takeParity, strb.takeStop, strb.pushChar})); // R1
  AST_TO_START_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.startFrame |=> !irqTimeout); // R10
  AST_TO_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqTimeout) |-> (state == S_IDLE)); // R10
endmodule

// File: rtl/uart_rxe_dp.sv
module uart_rxe_dp
  import uart_rxe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              rxIn,
  input  logic [2:0]        parityMode,
  input  logic [1:0]        trigSel,
  input  logic              rdPop,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        errStatus,
  output logic [AW-1:0]     fifoCount,
  output logic              fifoFull,
  output logic              irqLevel,
  output logic              irqError
);
  logic [DATA_W-1:0] shiftReg;
  logic              parSample, stopBad, allLow, parErr, dataPar;
  logic [DATA_W-1:0] memData [DEPTH];
  rxErr_t            memErr  [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count, thr;
  logic              ovrPend, empty, doPop, doPush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0; parSample <= 1'b0; stopBad <= 1'b0; allLow <= 1'b0;
    end else if (strb.startFrame) begin
      shiftReg <= '0; parSample <= 1'b0; stopBad <= 1'b0; allLow <= 1'b1;
    end else begin
      if (strb.takeData) shiftReg[strb.bitIdx] <= rxIn;
      if (strb.takeParity) parSample <= rxIn;
      if (strb.takeStop && !rxIn) stopBad <= 1'b1;
      if ((strb.takeData || strb.takeParity || strb.takeStop) && rxIn) allLow <= 1'b0;
    end
  end

  assign dataPar = ^shiftReg;
  always_comb begin
    unique case (parityMode)
      3'd1:    parErr = dataPar ^ parSample;
      3'd2:    parErr = ~(dataPar ^ parSample);
      3'd3:    parErr = ~parSample;
      3'd4:    parErr = parSample;
      default: parErr = 1'b0;
    endcase
  end

  assign empty  = (count == '0);
  assign doPop  = rdPop && !empty;
  assign doPush = strb.pushChar && (!fifoFull || doPop);

  always_ff @(posedge clk) begin
    if (doPush && !strb.flush) begin
      memData[wrPtr] <= shiftReg;
      memErr[wrPtr]  <= '{brk: allLow, frm: stopBad, par: parErr, ovr: 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0; ovrPend <= 1'b0;
    end else if (strb.flush) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0; ovrPend <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop) rdPtr <= rdPtr + AW'(1);
      count <= count + CW'(doPush) - CW'(doPop);
      if (doPop) ovrPend <= 1'b0;
      else if (strb.pushChar && fifoFull) ovrPend <= 1'b1;
    end
  end

  always_comb begin
    unique case (trigSel)
      2'd0:    thr = CW'(1);
      2'd1:    thr = CW'(DEPTH / 4);
      2'd2:    thr = CW'(DEPTH / 2);
      default: thr = CW'(DEPTH * 3 / 4);
    endcase
  end

  assign fifoCount = count[AW-1:0];
  assign fifoFull  = count[AW];
  assign rdData    = empty ? '0 : memData[rdPtr];
  assign errStatus = empty ? 4'd0 : (memErr[rdPtr] | {3'b000, ovrPend});
  assign irqLevel  = (count >= thr);
  assign irqError  = |errStatus;

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (fifoCount == '0 && !fifoFull && errStatus == 4'd0)); // R11
  AST_OVR_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushChar && fifoFull && !rdPop && !strb.flush) |=> errStatus[0]); // R6
  AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && !empty && !strb.pushChar && !strb.flush) |=> count == $past(count) - CW'(1)); // R5
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (!irqError && rdData == '0)); // R9
endmodule

// File: rtl/uart_rxe_top.sv
module uart_rxe_top
  import uart_rxe_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int OVS     = 16,
  parameter int TO_BITS = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              fifoClear,
  input  logic              subTick,
  input  logic              rxIn,
  input  logic [1:0]        dataBitsSel,
  input  logic [2:0]        parityMode,
  input  logic              stopSel,
  input  logic [1:0]        trigSel,
  input  logic              rdPop,
  input  logic              toAck,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        errStatus,
  output logic [AW-1:0]     fifoCount,
  output logic              fifoFull,
  output logic              irqLevel,
  output logic              irqError,
  output logic              irqTimeout
);
  rxStrobe_t strb;
  logic      parityOn;

  assign parityOn = (parityMode >= 3'd1) && (parityMode <= 3'd4);

  uart_rxe_ctrl #(.OVS(OVS), .TO_BITS(TO_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fifoClear(fifoClear),
    .subTick(subTick), .rxIn(rxIn), .dataBitsSel(dataBitsSel),
    .parityOn(parityOn), .stopSel(stopSel), .toAck(toAck),
    .strb(strb), .irqTimeout(irqTimeout)
  );

  uart_rxe_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxIn(rxIn),
    .parityMode(parityMode), .trigSel(trigSel), .rdPop(rdPop),
    .rdData(rdData), .errStatus(errStatus), .fifoCount(fifoCount),
    .fifoFull(fifoFull), .irqLevel(irqLevel), .irqError(irqError)
  );
endmodule

// File: tb/uart_rxe_top_bench.sv
module uart_rxe_top_bench;
  localparam int BIT_CYC = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rstN = 1'b0, rxEnable = 1'b0, fifoClear = 1'b0, subTick = 1'b0;
  logic rxIn = 1'b1, stopSel = 1'b0, rdPop = 1'b0, toAck = 1'b0;
  logic [1:0] dataBitsSel = 2'd3, trigSel = 2'd0;
  logic [2:0] parityMode = 3'd0;
  logic [7:0] rdData;
  logic [3:0] errStatus, fifoCount;
  logic fifoFull, irqLevel, irqError, irqTimeout;

  int nChecks = 0, nFails = 0;
  logic [11:0] q[$];
  logic ovrPend = 1'b0;

  uart_rxe_top u_uart_rxe_top (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fifoClear(fifoClear),
    .subTick(subTick), .rxIn(rxIn), .dataBitsSel(dataBitsSel),
    .parityMode(parityMode), .stopSel(stopSel), .trigSel(trigSel),
    .rdPop(rdPop), .toAck(toAck), .rdData(rdData), .errStatus(errStatus),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .irqLevel(irqLevel),
    .irqError(irqError), .irqTimeout(irqTimeout)
  );

  always #2.5 clk = ~clk;
  initial forever begin @(negedge clk); subTick = ~subTick; end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  task automatic waitCyc(input int n); repeat (n) @(negedge clk); endtask

  function automatic logic idealPar(input logic [7:0] d, input logic [2:0] m);
    case (m)
      3'd1: return ^d;
      3'd2: return ~^d;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // expected {err[3:0], data[7:0]} from the line bits and the configuration
  function automatic logic [11:0] expectFrom(input logic [11:0] b, input int len);
    int nb = int'(dataBitsSel) + 5;
    bit pOn = parityMode inside {3'd1, 3'd2, 3'd3, 3'd4};
    int ns = int'(stopSel) + 1;
    logic [7:0] d = '0;
    logic pe = 1'b0, fe = 1'b0, br;
    for (int i = 0; i < nb; i++) d[i] = b[1 + i];
    if (pOn) pe = (b[1 + nb] != idealPar(d, parityMode));
    for (int i = 0; i < ns; i++) if (!b[1 + nb + int'(pOn) + i]) fe = 1'b1;
    br = 1'b1;
    for (int i = 0; i < len; i++) if (b[i]) br = 1'b0;
    return {br, fe, pe, 1'b0, d};
  endfunction

  task automatic driveBits(input logic [11:0] v, input int len);
    for (int i = 0; i < len; i++) begin rxIn = v[i]; waitCyc(BIT_CYC); end
    rxIn = 1'b1;
  endtask

  // kind: 0 break, 1 parity flip, 2 bad stop, other clean
  task automatic sendChar(input logic [7:0] d, input int kind);
    int nb = int'(dataBitsSel) + 5;
    bit pOn = parityMode inside {3'd1, 3'd2, 3'd3, 3'd4};
    int ns = int'(stopSel) + 1;
    int len = 1 + nb + int'(pOn) + ns;
    logic [11:0] b = '1;
    logic [7:0] dm = '0;
    for (int i = 0; i < nb; i++) dm[i] = d[i];
    b[0] = 1'b0;
    for (int i = 0; i < nb; i++) b[1 + i] = d[i];
    if (pOn) b[1 + nb] = idealPar(dm, parityMode) ^ (kind == 1);
    if (kind == 2) b[1 + nb + int'(pOn) + int'($urandom % ns)] = 1'b0;
    if (kind == 0) b = '0;
    driveBits(b, len);
    if (q.size() == DEPTH) ovrPend = 1'b1;
    else q.push_back(expectFrom(b, len));
  endtask

  task automatic checkLevel(input string tag);
    int thr;
    case (trigSel) 2'd0: thr = 1; 2'd1: thr = 4; 2'd2: thr = 8; default: thr = 12; endcase
    check(fifoCount == 4'(q.size()) && fifoFull == (q.size() == DEPTH), "R7", {tag, " count"},
          {fifoFull, fifoCount}, q.size());
    check(irqLevel == (q.size() >= thr), "R8", {tag, " irqLevel"}, irqLevel, q.size() >= thr);
  endtask

  task automatic popCheck(input string tag);
    logic [11:0] e;
    logic [3:0] ee;
    e = q.pop_front();
    ee = e[11:8] | {3'b000, ovrPend};
    check(rdData == e[7:0], "R1", {tag, " data"}, rdData, e[7:0]);
    check(errStatus == ee, "R5", {tag, " err (R2 R3 R4 R6)"}, errStatus, ee);
    check(irqError == (ee != 0), "R9", {tag, " irqError"}, irqError, ee != 0);
    rdPop = 1'b1; waitCyc(1); rdPop = 1'b0;
    ovrPend = 1'b0;
  endtask

  task automatic clearModel(); q.delete(); ovrPend = 1'b0; endtask

  initial begin
    void'($urandom(32'd2024));
    waitCyc(4);
    // R13 reset state
    check(fifoCount == 0 && !fifoFull, "R13", "count after reset", {fifoFull, fifoCount}, 0);
    check(!irqLevel && !irqError && !irqTimeout, "R13", "irqs after reset",
          {irqLevel, irqError, irqTimeout}, 0);
    rstN = 1'b1; rxEnable = 1'b1;
    waitCyc(4);
    check(errStatus == 0 && rdData == 0, "R5", "empty head reads zero", {errStatus, rdData}, 0);

    // R1 8N1 and 5-bit right-justification
    dataBitsSel = 2'd3; parityMode = 3'd0; stopSel = 1'b0;
    sendChar(8'hA5, 7); waitCyc(BIT_CYC);
    popCheck("R1 8N1");
    dataBitsSel = 2'd0;
    sendChar(8'hFF, 7); waitCyc(BIT_CYC);
    check(rdData == 8'h1F, "R1", "5-bit upper zero", rdData, 8'h1F);
    popCheck("R1 5bit");

    // R12 glitch rejection
    dataBitsSel = 2'd3;
    rxIn = 1'b0; waitCyc(6); rxIn = 1'b1; waitCyc(20 * BIT_CYC);
    check(fifoCount == 0 && !fifoFull, "R12", "glitch gives no char", fifoCount, 0);

    // random batches: R1 R2 R3 R4 R5 R7 R8 R9
    for (int bt = 0; bt < 8; bt++) begin
      int n = 1 + int'($urandom % 14);
      dataBitsSel = 2'($urandom); parityMode = 3'($urandom % 6);
      stopSel = 1'($urandom); trigSel = 2'($urandom);
      for (int k = 0; k < n; k++) begin
        int kd = int'($urandom % 8);
        sendChar(8'($urandom), kd);
        waitCyc(BIT_CYC);
      end
      checkLevel("batch");
      while (q.size() > 0) popCheck("batch");
      checkLevel("drained");
    end

    // R6 R7 overrun, full encoding
    dataBitsSel = 2'd3; parityMode = 3'd0; stopSel = 1'b0; trigSel = 2'd3;
    for (int k = 0; k < 17; k++) begin sendChar(8'(k + 1), 7); waitCyc(4); end
    check(fifoFull && fifoCount == 0, "R7", "full with count 0", {fifoFull, fifoCount}, 16);
    check(errStatus[0] == 1'b1, "R6", "overrun on head", errStatus, 1);
    checkLevel("full");
    popCheck("R6 first");
    check(errStatus[0] == 1'b0 && rdData == 8'h02, "R6", "overrun only first",
          {errStatus, rdData}, 12'h002);
    popCheck("R6 second");

    // R11 fifoClear
    fifoClear = 1'b1; waitCyc(1); fifoClear = 1'b0; clearModel();
    check(fifoCount == 0 && !fifoFull && errStatus == 0, "R11", "fifoClear empties",
          {fifoFull, fifoCount}, 0);

    // R10 timeout with the queue drained
    toAck = 1'b1; waitCyc(1); toAck = 1'b0;
    sendChar(8'h3C, 7);
    popCheck("R10 char");
    check(irqTimeout == 1'b0, "R10", "no timeout yet", irqTimeout, 0);
    waitCyc(200);
    check(irqTimeout == 1'b1 && fifoCount == 0, "R10", "timeout on empty queue", irqTimeout, 1);
    toAck = 1'b1; waitCyc(1); toAck = 1'b0;
    check(irqTimeout == 1'b0, "R10", "toAck clears", irqTimeout, 0);

    // R8 directed threshold 4
    trigSel = 2'd1;
    for (int k = 0; k < 3; k++) begin sendChar(8'(k), 7); waitCyc(4); end
    check(irqLevel == 1'b0, "R8", "3 below threshold 4", irqLevel, 0);
    sendChar(8'h44, 7); waitCyc(4);
    check(irqLevel == 1'b1, "R8", "4 at threshold 4", irqLevel, 1);

    // R11 rxEnable low
    rxEnable = 1'b0; waitCyc(2); rxEnable = 1'b1; clearModel(); waitCyc(2);
    check(fifoCount == 0 && !fifoFull && !irqLevel, "R11", "disable empties",
          {fifoFull, fifoCount}, 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule